// File: doc/BRIEF.md
# PWM fault shutdown and restart guard

This block sits beside a PWM generator and takes over its output pins when something goes wrong. External fault pins are brought into the clock domain, masked by a per-source enable field and OR-ed together. An active enabled fault sets a shutdown status bit. On the same clock edge the block asserts override enables on all four PWM pins (A, B, C, D). Each override puts its pin in a programmed safe state: driven low or released to high impedance. Pins A and C share one safe-state code and pins B and D share another.

The status bit can be cleared in two ways. With automatic restart selected it clears by itself once no enabled fault is active. Otherwise software must clear it with a write. Software can also write the bit to one to force a shutdown. Writes are ignored while an enabled fault is active. Clearing the status bit does not release the pins at once. The override is dropped only at the next period-start pulse from the PWM generator that arrives while the status bit is already clear. A shutdown therefore always lasts to a period boundary.

Top module: `pwm_fault_guard`

## Requirements
- R1: A fault pin that is high and enabled in `src_sel` sets `shut` and asserts all of `ovr_en` from the third rising edge that samples it high. A fault pin whose `src_sel` bit is 0 has no effect.
- R2: While a pin is overridden, safe-state code bit 0 equal to 1 sets that pin's `ovr_hiz` (high impedance). Codes 00 and 10 leave `ovr_hiz` at 0, which means the pin is driven low. `safe_ac` applies to pins A and C (indices 0 and 2) and `safe_bd` to pins B and D (indices 1 and 3). `ovr_hiz` is 0 whenever `ovr_en` is 0.
- R3: Once asserted, `ovr_en` stays asserted through every clock edge at which `period_start` is low.
- R4: With `auto_restart` = 1, `shut` clears on the edge after the synchronised enabled faults all go low, provided no write occurs on that edge.
- R5: With `auto_restart` = 0, `shut` stays set after the fault goes away. It clears only on an edge where `stat_wr` = 1 and `stat_wdata` = 0.
- R6: `ovr_en` deasserts only on an edge where `period_start` = 1 and `shut` is already 0 and stays 0.
- R7: A write to `shut` (`stat_wr` = 1) on an edge where an enabled synchronised fault is active has no effect.
- R8: A write with `stat_wdata` = 1 while no fault is active sets `shut` and asserts `ovr_en` on that edge.
- R9: After reset, `shut`, `ovr_en` and `ovr_hiz` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fault_in | input | N_FAULT | Asynchronous fault pins, active high |
| src_sel | input | N_FAULT | Per-source enable for the fault pins |
| safe_ac | input | 2 | Safe-state code for pins A and C |
| safe_bd | input | 2 | Safe-state code for pins B and D |
| auto_restart | input | 1 | 1 = status clears when the fault goes away |
| stat_wr | input | 1 | Software write strobe for the status bit |
| stat_wdata | input | 1 | Value written to the status bit |
| period_start | input | 1 | One-cycle pulse at each PWM period start |
| shut | output | 1 | Shutdown status bit |
| ovr_en | output | 4 | Per-pin override enable (A, B, C, D at index 0..3) |
| ovr_hiz | output | 4 | Per-pin high impedance when overridden, else driven low |

## Verification
The bench targets release timing. It clears the status bit in the middle of a period and then checks that the pins stay overridden until the following period-start pulse. A design that released on the clear itself, or on a period start that coincides with the clear, would drop `ovr_en` early. It also writes zero while a fault is still present, where a design that lets the write through would drop `shut` under a live fault. With automatic restart off it removes the fault and checks that `shut` holds. A masked fault must produce no shutdown, which catches a design that ignores `src_sel`. The bench also measures the exact three-edge latency from the pin, which exposes a missing or extra synchroniser stage. Mixed safe-state codes catch pairs that are swapped between A/C and B/D.

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard #(
  parameter int N_FAULT = 3,
  parameter int N_PIN   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_FAULT-1:0] fault_in,
  input  logic [N_FAULT-1:0] src_sel,
  input  logic [1:0]         safe_ac,
  input  logic [1:0]         safe_bd,
  input  logic               auto_restart,
  input  logic               stat_wr,
  input  logic               stat_wdata,
  input  logic               period_start,
  output logic               shut,
  output logic [N_PIN-1:0]   ovr_en,
  output logic [N_PIN-1:0]   ovr_hiz
);

  logic [N_FAULT-1:0] sync1, sync2;
  logic fault_act, shut_nxt, held;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= fault_in;
      sync2 <= sync1;
    end

  assign fault_act = |(sync2 & src_sel);
  assign shut_nxt  = fault_act | (stat_wr ? stat_wdata : (shut & ~auto_restart));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shut <= 1'b0;
      held <= 1'b0;
    end else begin
      shut <= shut_nxt;
      held <= shut_nxt | (held & ~(period_start & ~shut));
    end

  for (genvar i = 0; i < N_PIN; i++) begin : g_pin
    logic [1:0] code;
    assign code       = (i % 2 == 0) ? safe_ac : safe_bd;
    assign ovr_en[i]  = held;
    assign ovr_hiz[i] = held & code[0];
  end

endmodule

// File: rtl/pwm_fault_guard_chk.sv
module pwm_fault_guard_chk #(
  parameter int N_FAULT = 3,
  parameter int N_PIN   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_FAULT-1:0] fault_in,
  input logic [N_FAULT-1:0] src_sel,
  input logic [1:0]         safe_ac,
  input logic [1:0]         safe_bd,
  input logic               auto_restart,
  input logic               stat_wr,
  input logic               stat_wdata,
  input logic               period_start,
  input logic               shut,
  input logic [N_PIN-1:0]   ovr_en,
  input logic [N_PIN-1:0]   ovr_hiz
);

  p_fault_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(fault_in, 3) & $past(src_sel))) |-> shut);

  p_shut_overrides_r1: assert property (@(posedge clk) disable iff (!rst_n)
    shut |-> ovr_en[0]);

  p_hiz_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_en[1] |-> (ovr_hiz[1] == safe_bd[0] && ovr_hiz[0] == safe_ac[0]));

  p_hiz_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ovr_en[2] |-> !ovr_hiz[2]);

  p_hold_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_en[3] && !period_start) |=> ovr_en[3]);

  p_auto_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shut && auto_restart && !stat_wr && !(|($past(fault_in, 2) & src_sel))) |=> !shut);

  p_release_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr_en[0]) |-> ($past(period_start) && !$past(shut) && !shut));

  p_write_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !stat_wdata && (|($past(fault_in, 2) & src_sel))) |=> shut);

endmodule

bind pwm_fault_guard pwm_fault_guard_chk #(.N_FAULT(N_FAULT), .N_PIN(N_PIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .src_sel(src_sel),
  .safe_ac(safe_ac), .safe_bd(safe_bd), .auto_restart(auto_restart),
  .stat_wr(stat_wr), .stat_wdata(stat_wdata), .period_start(period_start),
  .shut(shut), .ovr_en(ovr_en), .ovr_hiz(ovr_hiz)
);

// File: tb/test_pwm_fault_guard.sv
module test_pwm_fault_guard;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 3;

  logic clk = 0, rst_n = 0;
  logic [NF-1:0] fault_in = '0, src_sel = '0;
  logic [1:0] safe_ac = 0, safe_bd = 0;
  logic auto_restart = 0, stat_wr = 0, stat_wdata = 0, period_start = 0;
  logic shut;
  logic [3:0] ovr_en, ovr_hiz;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [NF-1:0] m_s1 = '0, m_s2 = '0;
  logic m_shut = 0, m_held = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_fault_guard #(.N_FAULT(NF), .N_PIN(4)) i_pwm_fault_guard (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .src_sel(src_sel),
    .safe_ac(safe_ac), .safe_bd(safe_bd), .auto_restart(auto_restart),
    .stat_wr(stat_wr), .stat_wdata(stat_wdata), .period_start(period_start),
    .shut(shut), .ovr_en(ovr_en), .ovr_hiz(ovr_hiz));

  function automatic logic exp_shut(logic cur, logic [NF-1:0] s2, logic [NF-1:0] sel,
                                    logic ar, logic wr, logic wd);
    if (|(s2 & sel)) return 1'b1;
    if (wr) return wd;
    return cur & ~ar;
  endfunction

  function automatic logic exp_held(logic cur, logic nxt_shut, logic cur_shut, logic ps);
    if (nxt_shut) return 1'b1;
    if (cur && ps && !cur_shut) return 1'b0;
    return cur;
  endfunction

  function automatic logic [3:0] exp_hiz(logic h, logic [1:0] ac, logic [1:0] bd);
    if (!h) return 4'b0;
    return {bd[0], ac[0], bd[0], ac[0]};
  endfunction

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cyc();
    logic ns, nh;
    ns = exp_shut(m_shut, m_s2, src_sel, auto_restart, stat_wr, stat_wdata);
    nh = exp_held(m_held, ns, m_shut, period_start);
    @(posedge clk);
    m_s2 = m_s1; m_s1 = fault_in; m_shut = ns; m_held = nh;
    @(negedge clk);
    stat_wr = 0; period_start = 0;
  endtask

  task automatic model_cmp();
    chk("R1 R4 R5 R7 R8 shut", {3'b0, shut}, {3'b0, m_shut});
    chk("R3 R6 ovr_en", ovr_en, {4{m_held}});
    chk("R2 ovr_hiz", ovr_hiz, exp_hiz(m_held, safe_ac, safe_bd));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 reset shut", {3'b0, shut}, 4'b0);
    chk("R9 reset ovr_en", ovr_en, 4'b0);
    chk("R9 reset ovr_hiz", ovr_hiz, 4'b0);

    // R1 masked source
    src_sel = 3'b001; fault_in = 3'b110;
    repeat (5) cyc();
    chk("R1 masked fault shut", {3'b0, shut}, 4'b0);

    // R1 latency of three edges
    fault_in = 3'b001; safe_ac = 2'b01; safe_bd = 2'b10;
    cyc(); cyc();
    chk("R1 not yet after two edges", {3'b0, shut}, 4'b0);
    cyc();
    chk("R1 shut after three edges", {3'b0, shut}, 4'b1);
    chk("R1 override asserted", ovr_en, 4'b1111);
    chk("R2 hiz A/C only", ovr_hiz, 4'b0101);

    // R7 clear write blocked during fault
    stat_wr = 1; stat_wdata = 0; cyc();
    chk("R7 write ignored under fault", {3'b0, shut}, 4'b1);

    // R5 no auto clear
    fault_in = 0;
    repeat (5) cyc();
    chk("R5 shut holds without write", {3'b0, shut}, 4'b1);
    period_start = 1; cyc();
    chk("R3 held over period start while shut", ovr_en, 4'b1111);

    // R5 / R6 software clear then release at boundary
    stat_wr = 1; stat_wdata = 0; period_start = 1; cyc();
    chk("R5 write clears shut", {3'b0, shut}, 4'b0);
    chk("R6 no release on coincident boundary", ovr_en, 4'b1111);
    repeat (3) cyc();
    chk("R6 held until next boundary", ovr_en, 4'b1111);
    period_start = 1; cyc();
    chk("R6 released at boundary", ovr_en, 4'b0000);
    chk("R2 hiz low when released", ovr_hiz, 4'b0000);

    // R4 automatic restart
    auto_restart = 1; fault_in = 3'b001; safe_ac = 2'b10; safe_bd = 2'b11;
    repeat (3) cyc();
    chk("R4 shut set", {3'b0, shut}, 4'b1);
    chk("R2 hiz B/D only", ovr_hiz, 4'b1010);
    fault_in = 0;
    repeat (2) cyc();
    chk("R4 still set while sync drains", {3'b0, shut}, 4'b1);
    cyc();
    chk("R4 auto cleared", {3'b0, shut}, 4'b0);
    period_start = 1; cyc();
    chk("R6 released after auto clear", ovr_en, 4'b0000);

    // R8 software forced shutdown
    auto_restart = 0; stat_wr = 1; stat_wdata = 1; cyc();
    chk("R8 write sets shut", {3'b0, shut}, 4'b1);
    chk("R8 write overrides pins", ovr_en, 4'b1111);
    stat_wr = 1; stat_wdata = 0; cyc();
    period_start = 1; cyc();
    chk("R6 release after forced shutdown", ovr_en, 4'b0000);

    // random phase against bench model
    for (int n = 0; n < 4000; n++) begin
      fault_in     = (($urandom % 8) == 0) ? NF'($urandom) : '0;
      if (($urandom % 50) == 0) src_sel = NF'($urandom);
      if (($urandom % 40) == 0) begin safe_ac = 2'($urandom); safe_bd = 2'($urandom); end
      if (($urandom % 60) == 0) auto_restart = ~auto_restart;
      stat_wr      = (($urandom % 10) == 0);
      stat_wdata   = (($urandom % 4) == 0);
      period_start = (($urandom % 7) == 0);
      cyc();
      model_cmp();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule